// File: doc/BRIEF.md
# Dual-Match Reloading Down-Counter Timer

This block is one timer channel. A counter loads a programmed start value, steps down by one on every tick, and loads the start value again after it has reached zero. A select input chooses the tick. It can be an external 1 MHz tick-enable strobe, or it can be every cycle of the bus clock. Two compare values can each mark a point inside the count-down. Zero marks one more point. At each of these points the interrupt line changes level, so the line records events by toggling and does not pulse.

Software reaches the channel through a simple register port with a write strobe, a two-bit register select and a registered read path. Through this port it can set or read the live count, the start value and both compare values. Separate inputs set the run, tick-select and overflow-interrupt controls. Bus address decoding and the grouping of channels are handled outside the block.

Top module: `dm_countdown_timer`

## Requirements
- R1: While running, each tick takes the count from a nonzero value c to c-1. A tick taken at count 0 loads the start value. With the bus clock selected, one period lasts start value plus one cycles.
- R2: When ext_sel is 1, the count moves only in cycles where ext_tick is 1. When ext_sel is 0, it moves in every clock cycle.
- R3: A compare value equal to or larger than the start value has no event of its own. It falls on the zero point and counts toward that point only as R5 allows.
- R4: An event happens on the tick that brings the count to a valid nonzero compare value. Because the counter runs down, the larger compare point fires first in each period, then the smaller one, then zero.
- R5: The tick that brings the count from 1 to 0 raises an event only when irq_ovf_en is 1, or when either stored compare value is exactly 0.
- R6: Every event inverts irq_o, and no cycle inverts it more than once. Two compare values that fall on the same count produce a single inversion. In any cycle without an event, irq_o keeps its level.
- R7: Register select codes: 0 is the live count, 1 is the start value, 2 is compare A, 3 is compare B. A write to code 0 while running sets the count to the written value, and a tick in that same cycle does not change the count.
- R8: While run_en is 0, the count keeps its value, and a write to code 0 has no effect.
- R9: rd_data shows the register chosen by rd_sel one clock edge later. Code 0 reads as the live count while running and reads as zero while stopped.
- R10: After run_en rises, the first tick loads the start value. It does not step down.
- R11: If a nonzero start value is written over a start value of zero while running, the next tick loads the new value.
- R12: Reset clears the count, the start value, both compare values, rd_data and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_tick | input | 1 | External 1 MHz tick-enable strobe |
| run_en | input | 1 | Run control for the channel |
| ext_sel | input | 1 | 1 selects ext_tick as the tick, 0 selects every bus clock |
| irq_ovf_en | input | 1 | Allows an event at zero |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | CNT_W | Registered read data |
| irq_o | output | 1 | Interrupt level, inverted on each event |

## Verification
The main check sweeps every pair of compare values from 0 up to one above the start value, across several start values and with the overflow enable both on and off, all on the bus-clock tick. Over one whole period the bench counts how often irq_o changes and compares that with an arithmetic count of the distinct event points. This shows apart compare values that are out of range, equal to each other, zero, or valid. Single-stepped runs driven by ext_tick then check on which tick each inversion falls, which establishes the order larger compare, smaller compare, zero. Frozen-tick sequences check the rules for start, stop, count writes and restarting from a start value of zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_MATCH = 2;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_MATCH_A = 2'd2,
    SEL_MATCH_B = 2'd3
  } tmr_sel_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic ext_sel,
  input  logic ext_tick,
  output logic tick
);
  // bus-clock source means a tick in every cycle
  assign tick = ext_sel ? ext_tick : 1'b1;
endmodule

// File: rtl/tmr_event_eval.sv
module tmr_event_eval #(
  parameter int CNT_W = 32,
  parameter int NM    = 2
) (
  input  logic [CNT_W-1:0]        probe,
  input  logic [CNT_W-1:0]        reload,
  input  logic [NM-1:0][CNT_W-1:0] match,
  input  logic                    ovf_en,
  output logic                    hit
);
  logic [NM-1:0] m_hit;
  logic [NM-1:0] m_zero;

  genvar gi;
  generate
    for (gi = 0; gi < NM; gi++) begin : g_cmp
      logic [CNT_W-1:0] eff;
      // out-of-range compare collapses onto the zero point
      assign eff        = (match[gi] < reload) ? match[gi] : '0;
      assign m_hit[gi]  = (probe != '0) && (probe == eff);
      assign m_zero[gi] = (match[gi] == '0);
    end
  endgenerate

  assign hit = (probe == '0) ? (ovf_en | (|m_zero)) : (|m_hit);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_en,
  input  logic [CNT_W-1:0] reload,
  input  logic             ld_now,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic [CNT_W-1:0] step_val
);
  logic run_q;
  logic pend;
  logic rise;
  logic want_now;

  assign rise     = run_en & ~run_q;
  assign want_now = pend | rise;
  assign step     = run_en & ~ld_now & tick & ~want_now & (cnt != '0);
  assign step_val = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      run_q <= run_en;
      if (!run_en) begin
        pend <= 1'b0;
      end else if (ld_now) begin
        cnt  <= ld_data;
        pend <= kick;
      end else begin
        pend <= (want_now & ~tick) | kick;
        if (tick) cnt <= (want_now || cnt == '0) ? reload : step_val;
      end
    end
  end

  // R1: a plain step lowers the count by exactly one
  a_r1_step_down: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == $past(cnt) - 1'b1));
  // R8: stopped channel keeps its count
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(cnt));
  // R10: first tick after start loads the reload value
  a_r10_start_load: assert property (@(posedge clk) disable iff (rst)
    (run_en && !run_q && tick && !ld_now) |=> (cnt == $past(reload)));
endmodule

// File: rtl/dm_countdown_timer.sv
module dm_countdown_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_tick,
  input  logic             run_en,
  input  logic             ext_sel,
  input  logic             irq_ovf_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0]               reload_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [CNT_W-1:0]               cnt;
  logic [CNT_W-1:0]               step_val;
  logic                           step;
  logic                           hit;
  logic                           tick;
  logic                           ld_now;
  logic                           kick;
  tmr_sel_e                       wsel;
  tmr_sel_e                       rsel;

  assign wsel   = tmr_sel_e'(wr_sel);
  assign rsel   = tmr_sel_e'(rd_sel);
  assign ld_now = wr_en && (wsel == SEL_COUNT) && run_en;
  assign kick   = wr_en && (wsel == SEL_RELOAD) && run_en &&
                  (reload_q == '0) && (wr_data != '0);

  tmr_tick_sel u_tick (
    .ext_sel  (ext_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run_en   (run_en),
    .reload   (reload_q),
    .ld_now   (ld_now),
    .ld_data  (wr_data),
    .kick     (kick),
    .cnt      (cnt),
    .step     (step),
    .step_val (step_val)
  );

  tmr_event_eval #(.CNT_W(CNT_W), .NM(NUM_MATCH)) u_eval (
    .probe  (step_val),
    .reload (reload_q),
    .match  (match_q),
    .ovf_en (irq_ovf_en),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) reload_q <= '0;
    else if (wr_en && wsel == SEL_RELOAD) reload_q <= wr_data;
  end

  genvar gm;
  generate
    for (gm = 0; gm < NUM_MATCH; gm++) begin : g_match
      always_ff @(posedge clk) begin
        if (rst) match_q[gm] <= '0;
        else if (wr_en && wr_sel[1] && (int'(wr_sel[0]) == gm)) match_q[gm] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else if (step && hit) irq_o <= ~irq_o;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rsel)
        SEL_COUNT:   rd_data <= run_en ? cnt : '0;
        SEL_RELOAD:  rd_data <= reload_q;
        SEL_MATCH_A: rd_data <= match_q[0];
        default:     rd_data <= match_q[1];
      endcase
    end
  end

  // R6: no event, no change of level
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !(step && hit) |=> $stable(irq_o));
  // R9: count reads zero while stopped
  a_r9_rd_stopped: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'd0 && !run_en) |=> (rd_data == '0));
  // R7: a count write while running takes effect next edge
  a_r7_count_wr: assert property (@(posedge clk) disable iff (rst)
    ld_now |=> (cnt == $past(wr_data)));
endmodule

// File: tb/test_dm_countdown_timer.sv
`timescale 1ns/1ps
module test_dm_countdown_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_tick = 1'b0;
  logic         run_en = 1'b0;
  logic         ext_sel = 1'b0;
  logic         irq_ovf_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = 2'd0;
  logic [W-1:0] rd_data;
  logic         irq_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  dm_countdown_timer #(.CNT_W(W)) i_dm_countdown_timer (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .run_en(run_en),
    .ext_sel(ext_sel), .irq_ovf_en(irq_ovf_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, output int val);
    @(negedge clk);
    rd_sel = 2'(sel);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic pulse;
    @(negedge clk);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  function automatic int exp_toggle(int c, int r, int a, int b, int ov);
    int nv;
    if (c == 0) return 0;
    nv = c - 1;
    if (nv == 0) return (ov != 0 || a == 0 || b == 0) ? 1 : 0;
    return ((a < r && a == nv) || (b < r && b == nv)) ? 1 : 0;
  endfunction

  // stepped run from count r on external ticks, tick by tick
  task automatic step_run(input int r, input int a, input int b, input int ov, input string tag);
    int c;
    logic prev;
    @(negedge clk);
    run_en = 1'b0; ext_sel = 1'b1; irq_ovf_en = ov[0];
    wr(1, r); wr(2, a); wr(3, b);
    @(negedge clk); run_en = 1'b1;
    wr(0, r);
    c = r;
    for (int k = 0; k < 2 * r + 2; k++) begin
      prev = irq_o;
      pulse();
      chk((irq_o != prev) == (exp_toggle(c, r, a, b, ov) != 0), tag,
          int'(irq_o != prev), exp_toggle(c, r, a, b, ov));
      c = (c == 0) ? r : c - 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int v, v2, held, e, n;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk(irq_o == 1'b0, "R12 irq", int'(irq_o), 0);
    rd(0, v); chk(v == 0, "R12 count", v, 0);
    rd(1, v); chk(v == 0, "R12 reload", v, 0);
    rd(2, v); chk(v == 0, "R12 matchA", v, 0);
    rd(3, v); chk(v == 0, "R12 matchB", v, 0);

    // R7 register map readback
    wr(1, 40); wr(2, 11); wr(3, 22);
    rd(1, v); chk(v == 40, "R7 reload readback", v, 40);
    rd(2, v); chk(v == 11, "R7 matchA readback", v, 11);
    rd(3, v); chk(v == 22, "R7 matchB readback", v, 22);

    // R2 frozen external tick, R7 count write while running, R10
    ext_sel = 1'b1;
    @(negedge clk); run_en = 1'b1;
    wr(0, 50);
    rd(0, v); chk(v == 50, "R7 count write", v, 50);
    repeat (10) @(negedge clk);
    rd(0, v); chk(v == 50, "R2 no tick no move", v, 50);
    pulse();
    rd(0, v); chk(v == 49, "R2 ext tick step", v, 49);
    pulse(); pulse();
    rd(0, v); chk(v == 47, "R1 R9 live count", v, 47);

    // R8 stop, ignored count write, hold; R10 restart load
    held = v;
    @(negedge clk); run_en = 1'b0;
    rd(0, v); chk(v == 0, "R9 stopped reads zero", v, 0);
    wr(0, 77);
    pulse(); pulse();
    @(negedge clk); run_en = 1'b1;
    rd(0, v); chk(v == held, "R8 hold and ignore", v, held);
    pulse();
    rd(0, v); chk(v == 40, "R10 start loads reload", v, 40);
    pulse();
    rd(0, v); chk(v == 39, "R10 then steps", v, 39);

    // R11 restart from zero start value
    @(negedge clk); run_en = 1'b0;
    wr(1, 0);
    @(negedge clk); run_en = 1'b1;
    pulse();
    rd(0, v); chk(v == 0, "R11 idle at zero", v, 0);
    pulse();
    rd(0, v); chk(v == 0, "R11 stays zero", v, 0);
    wr(1, 20);
    pulse();
    rd(0, v); chk(v == 20, "R11 restart load", v, 20);
    pulse();
    rd(0, v2); chk(v2 == 19, "R11 counting", v2, 19);

    // R4 order, R3 out of range, R5 zero rule, R6 coincide
    step_run(10, 7, 3, 0, "R4 order a>b");
    step_run(10, 3, 7, 0, "R4 order b>a");
    step_run(10, 7, 3, 1, "R5 ovf zero");
    step_run(10, 12, 4, 0, "R3 out of range");
    step_run(10, 0, 5, 0, "R5 zero via match");
    step_run(10, 6, 6, 0, "R6 coincide");

    // sweep on bus clock: R1 R3 R5 R6 toggle count per period
    for (int r = 1; r <= 6; r++) begin
      for (int a = 0; a <= r + 1; a++) begin
        for (int b = 0; b <= r + 1; b++) begin
          for (int ov = 0; ov < 2; ov++) begin
            @(negedge clk);
            run_en = 1'b0; ext_sel = 1'b0; irq_ovf_en = ov[0];
            wr(1, r); wr(2, a); wr(3, b);
            @(negedge clk); run_en = 1'b1;
            repeat (3) @(negedge clk);
            e = ((ov != 0 || a == 0 || b == 0) ? 1 : 0)
              + ((a < r && a != 0) ? 1 : 0)
              + ((b < r && b != 0 && b != a) ? 1 : 0);
            n = 0;
            prev = irq_o;
            for (int k = 0; k < r + 1; k++) begin
              @(negedge clk);
              if (irq_o != prev) n++;
              prev = irq_o;
            end
            chk(n == e, "R1 R3 R5 R6 sweep", n, e);
          end
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule